// File: doc/BRIEF.md
# Differential Clock Stop and Enable Gate

This block sits between an internal free-running clock and seven true/complement output pairs. It gates each pair against four controls: a global active-low stop input, an enable pin for each pair, an enable bit for each pair held in a register elsewhere, and a stop-mode bit for each pair. A global drive-mode bit decides how a stopped pair is parked. It can either drive true high and complement low, or release the pair to high impedance. Every output is registered on the fast system clock. The internal clock arrives as a level that the system clock samples, and the block finds its rising edges itself.

A stop is honoured only by pairs whose stop-mode bit is set, and only at the next rising edge of the internal clock. The pair therefore parks at the end of a complete low phase and never cuts a pulse short. Pairs whose mode bit is clear keep toggling. When the stop input is released, every parked pair resumes on the same rising edge of the internal clock, a fixed number of internal periods later. The first phase it drives is a full high phase.

Top module: `difgate_top`

## Requirements
- R1: While rst_n is low, every pair reads dif_t=0, dif_c=1 and dif_oe=0.
- R2: dif_oe[i] is 1 only if both oe_pin[i] and reg_en[i] were 1 at the previous system clock edge. A clear reg_en bit disables the pair whatever the state of stop_n.
- R3: Whenever dif_oe[i] is 1, dif_c[i] equals the inverse of dif_t[i].
- R4: A pair that is not stopped shows, on dif_t, the value that ref_lvl had one system clock earlier.
- R5: stop_n passes through two synchronizer flops. Stopping is decided only on the cycles in which a rising edge of ref_lvl is seen. A pair whose stop_mode bit is 0 keeps toggling during a stop.
- R6: A stopped pair with hiz_mode=0 holds dif_t=1 and dif_c=0, driven, and its oe follows R2.
- R7: A stopped pair with hiz_mode=1 has dif_oe=0.
- R8: After the synchronized stop input returns high, stopped pairs resume at the third rising edge of ref_lvl. A stop that reappears before then cancels the restart.
- R9: A stop_mode bit is sampled only at ref_lvl rising edges. Clearing it during a stop resumes that pair at the next rising edge, so no phase of dif_t is shorter than half a ref_lvl period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples everything |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_lvl | input | 1 | Level of the internal free-running clock |
| stop_n | input | 1 | Asynchronous active-low global stop request |
| oe_pin | input | 7 | Enable pin for each pair, 1 = enabled |
| reg_en | input | 7 | Register enable for each pair, 1 = enabled |
| stop_mode | input | 7 | 1 = pair obeys stop, 0 = free running |
| hiz_mode | input | 1 | Parking of stopped pairs: 0 = driven high, 1 = high impedance |
| dif_t | output | 7 | True output of each pair |
| dif_c | output | 7 | Complement output of each pair |
| dif_oe | output | 7 | Output drive enable of each pair, 1 = driven |

## Verification
The assertions assume that ref_lvl is a clean clock, many system clock cycles per phase. This lets a rising edge be seen as a single-cycle event, and it lets the parked state be judged against that edge alone. They also assume that stop_n may change in any cycle, because it passes through the synchronizer first. The stimulus toggles ref_lvl every three system cycles and changes only stop_n and the control bits, at random moments. Stop pulses are drawn both shorter and longer than the restart window, so that both cancelled and completed restarts occur.

// File: rtl/difgate_pkg.sv
package difgate_pkg;
    parameter int LANES_DEF   = 7;
    parameter int RESTART_DEF = 3;

    typedef struct packed {
        logic st;
        logic t;
        logic c;
        logic oe;
    } lane_state_t;
endpackage

// File: rtl/difgate_sync.sv
module difgate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/difgate_seq.sv
module difgate_seq #(
    parameter int RESTART_PER = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_lvl,
    input  logic stop_n,
    output logic rise,
    output logic hold
);
    localparam int CW = (RESTART_PER < 2) ? 1 : $clog2(RESTART_PER);
    localparam logic [CW-1:0] LAST = CW'(RESTART_PER - 1);

    typedef struct packed {
        logic          refp;
        logic          pend;
        logic [CW-1:0] cnt;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic       stop_sync_n;

    difgate_sync #(.STAGES(2)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (stop_n),
        .dout (stop_sync_n)
    );

    always_comb begin
        s_d      = s_q;
        s_d.refp = ref_lvl;
        rise     = ref_lvl & ~s_q.refp;
        hold     = ~stop_sync_n | (s_q.pend & (s_q.cnt != LAST));
        if (rise) begin
            if (!stop_sync_n) begin
                s_d.pend = 1'b1;
                s_d.cnt  = '0;
            end else if (s_q.pend) begin
                if (s_q.cnt == LAST) begin
                    s_d.pend = 1'b0;
                    s_d.cnt  = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= LAST);

    // R8
    idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.pend |-> s_q.cnt == '0);
endmodule

// File: rtl/difgate_lane.sv
module difgate_lane
    import difgate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_lvl,
    input  logic rise,
    input  logic hold,
    input  logic en_pin,
    input  logic reg_en,
    input  logic mode,
    input  logic hiz_mode,
    output logic dif_t,
    output logic dif_c,
    output logic dif_oe
);
    lane_state_t l_d, l_q;

    always_comb begin
        l_d    = l_q;
        l_d.st = rise ? (hold & mode) : l_q.st;
        l_d.t  = l_d.st | ref_lvl;
        l_d.c  = ~l_d.t;
        l_d.oe = en_pin & reg_en & ~(l_d.st & hiz_mode);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) l_q <= '{st: 1'b0, t: 1'b0, c: 1'b1, oe: 1'b0};
        else        l_q <= l_d;
    end

    assign dif_t  = l_q.t;
    assign dif_c  = l_q.c;
    assign dif_oe = l_q.oe;

    // R2
    dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_pin & reg_en) |-> !l_q.oe);

    // R9
    stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(l_q.st) |-> $past(rise));

    // R6
    parked_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q.oe && l_q.st && $past(l_q.st)) |-> (l_q.t && !l_q.c));

    // R7
    hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q.st && $past(hiz_mode)) |-> !l_q.oe);
endmodule

// File: rtl/difgate_top.sv
module difgate_top
    import difgate_pkg::*;
#(
    parameter int LANES       = LANES_DEF,
    parameter int RESTART_PER = RESTART_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_lvl,
    input  logic             stop_n,
    input  logic [LANES-1:0] oe_pin,
    input  logic [LANES-1:0] reg_en,
    input  logic [LANES-1:0] stop_mode,
    input  logic             hiz_mode,
    output logic [LANES-1:0] dif_t,
    output logic [LANES-1:0] dif_c,
    output logic [LANES-1:0] dif_oe
);
    logic rise;
    logic hold;

    difgate_seq #(.RESTART_PER(RESTART_PER)) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_lvl(ref_lvl),
        .stop_n (stop_n),
        .rise   (rise),
        .hold   (hold)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        difgate_lane lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .ref_lvl (ref_lvl),
            .rise    (rise),
            .hold    (hold),
            .en_pin  (oe_pin[g]),
            .reg_en  (reg_en[g]),
            .mode    (stop_mode[g]),
            .hiz_mode(hiz_mode),
            .dif_t   (dif_t[g]),
            .dif_c   (dif_c[g]),
            .dif_oe  (dif_oe[g])
        );
    end

    // R3
    compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dif_oe & (dif_t ^ ~dif_c)) == '0);
endmodule

// File: tb/difgate_top_tb_top.sv
`timescale 1ns/1ps
module difgate_top_tb_top;
    localparam int N    = 7;
    localparam int HALF = 3;
    localparam int RP   = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ref_lvl = 1'b0;
    logic         stop_n = 1'b1;
    logic [N-1:0] oe_pin = '0, reg_en = '0, stop_mode = '0;
    logic         hiz_mode = 1'b0;
    logic [N-1:0] dif_t, dif_c, dif_oe;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    difgate_top #(.LANES(N), .RESTART_PER(RP)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_lvl(ref_lvl), .stop_n(stop_n),
        .oe_pin(oe_pin), .reg_en(reg_en), .stop_mode(stop_mode),
        .hiz_mode(hiz_mode), .dif_t(dif_t), .dif_c(dif_c), .dif_oe(dif_oe)
    );

    // reference model, written from the requirements
    logic         m_s1, m_s2, m_refp, m_pend;
    int           m_cnt;
    logic [N-1:0] m_st, m_t, m_oe;

    function automatic logic [N-1:0] exp_oe(input logic [N-1:0] st_n,
                                            input logic hz);
        return oe_pin & reg_en & ~(st_n & {N{hz}});
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_refp <= 1'b0; m_pend <= 1'b0;
            m_cnt <= 0; m_st <= '0; m_t <= '0; m_oe <= '0;
        end else begin
            logic         rise_now, stopping;
            logic [N-1:0] st_n;
            rise_now = ref_lvl & ~m_refp;
            stopping = !m_s2 || (m_pend && m_cnt != RP - 1);
            st_n = rise_now ? (stopping ? stop_mode : '0) : m_st;
            if (rise_now) begin
                if (!m_s2) begin m_pend <= 1'b1; m_cnt <= 0; end
                else if (m_pend) begin
                    if (m_cnt == RP - 1) begin m_pend <= 1'b0; m_cnt <= 0; end
                    else m_cnt <= m_cnt + 1;
                end
            end
            m_s1 <= stop_n; m_s2 <= m_s1; m_refp <= ref_lvl;
            m_st <= st_n;
            m_t  <= st_n | {N{ref_lvl}};
            m_oe <= exp_oe(st_n, hiz_mode);
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(dif_oe == m_oe, "R2 R7 oe", dif_oe, m_oe);
            chk((dif_t & m_oe) == (m_t & m_oe), "R4 R5 R6 R8 R9 true", dif_t & m_oe, m_t & m_oe);
            chk((dif_oe & (dif_c ^ ~dif_t)) == '0, "R3 compl", dif_c, ~dif_t);
        end
    end

    // internal free-running clock
    initial begin
        forever begin
            repeat (HALF) @(negedge clk);
            ref_lvl = ~ref_lvl;
        end
    end

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    int lane0_toggles;

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(dif_t == '0 && dif_c == '1 && dif_oe == '0, "R1 reset",
            {dif_t[3:0], dif_c[2:0]}, 7'b0000111);
        rst_n = 1'b1;
        oe_pin = '1; reg_en = '1; stop_mode = 7'b1111110; hiz_mode = 1'b0;
        repeat (20) @(negedge clk);

        // directed: long driven stop, lane 0 free running
        stop_n = 1'b0;
        repeat (20) @(negedge clk);
        lane0_toggles = 0;
        for (int k = 0; k < 30; k++) begin
            logic p;
            p = dif_t[0];
            @(negedge clk);
            if (dif_t[0] != p) lane0_toggles++;
        end
        // R6 parked high, driven
        chk(dif_t[6:1] == '1 && dif_c[6:1] == '0 && dif_oe[6:1] == '1,
            "R6 parked", {1'b0, dif_t[6:1]}, 7'b0111111);
        // R5 free-running lane kept toggling
        chk(lane0_toggles >= 8, "R5 freerun", 7'(lane0_toggles), 7'd8);
        // R7 Hi-Z parking
        hiz_mode = 1'b1;
        repeat (2) @(negedge clk);
        chk(dif_oe[6:1] == '0, "R7 hiz", {1'b0, dif_oe[6:1]}, 7'b0);
        // R2 register disable during stop
        hiz_mode = 1'b0; reg_en[6] = 1'b0;
        repeat (2) @(negedge clk);
        chk(dif_oe[6] == 1'b0, "R2 regdis", {6'b0, dif_oe[6]}, 7'b0);
        reg_en = '1;
        // R8 release: parked lanes stay high until restart
        stop_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(dif_t[6:1] == '1, "R8 early", {1'b0, dif_t[6:1]}, 7'b0111111);
        repeat (60) @(negedge clk);

        // random phase
        for (int it = 0; it < 600; it++) begin
            int wait_c;
            case ($urandom_range(0, 5))
                0: stop_n = ~stop_n;
                1: stop_mode = 7'($urandom);
                2: oe_pin = 7'($urandom) | 7'($urandom);
                3: reg_en = 7'($urandom) | 7'($urandom);
                4: hiz_mode = 1'($urandom);
                default: stop_n = 1'($urandom);
            endcase
            wait_c = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 12)
                                                 : $urandom_range(10, 80);
            repeat (wait_c) @(negedge clk);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule